// File: doc/BRIEF.md
# Bitboard Geometry Transform Unit

This unit takes a 64-bit word that encodes an 8x8 board and returns the same board after a geometric transform. Board square `i` sits at bit `i`. Index bits `i[2:0]` give the column (X) and index bits `i[5:3]` give the row (Y). A 3-bit opcode picks one of six transforms: identity, left-right mirror, top-bottom mirror, half turn, transpose, or quarter turn.

No transform is held as a wiring table. Each one is built from two index-arithmetic stages. The first is a generalized reverse, which sends bit `i` to bit `i XOR m`. The second is a generalized zip, which sends bit `i` to the bit whose index is `i` rotated left by one place over an index field. It can be applied up to three times.

A small decoder turns the opcode into a reverse mask and a zip count. The datapath applies the reverse first and then the zips, and registers the result. An input word presented with its valid flag produces its transformed word, with a matching valid flag, one clock later.

Top module: `bbx_transform`

## Requirements
- R1: While `rstN` is low, and after it is released with no input accepted, `outValid` is 0 and `outBoard` is all zeros.
- R2: `outValid` in each cycle equals `inValid` from the cycle before. The result for a word accepted at a clock edge appears on `outBoard` after that edge.
- R3: When `inValid` is low at a clock edge, `outBoard` keeps its value, whatever `inBoard` and `inOp` are.
- R4: Opcode 3'b000 (keep) and the unused codes 3'b110 and 3'b111 return the input word unchanged.
- R5: Opcode 3'b001 (left-right mirror) moves input bit `i` to output bit `i XOR 7`.
- R6: Opcode 3'b010 (top-bottom mirror) moves input bit `i` to output bit `i XOR 56`, which is a byte swap.
- R7: Opcode 3'b011 (half turn) moves input bit `i` to output bit `i XOR 63`, which is a full bit reverse.
- R8: Opcode 3'b100 (transpose) moves input bit `i` to output bit `{i[2:0], i[5:3]}`. This is three whole-index zips. Transposing twice gives back the original board.
- R9: Opcode 3'b101 (quarter turn) moves input bit `i` to output bit `{j[2:0], j[5:3]}`, where `j = i XOR 56`. Four quarter turns give back the original board.
- R10: Every opcode is a permutation, so the output has the same number of set bits as the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | The word on `inBoard` is to be transformed at this edge |
| inOp | input | 3 | Transform selector (encodings in R4 to R9) |
| inBoard | input | 64 | Board word to transform |
| outValid | output | 1 | `outBoard` holds a freshly transformed word |
| outBoard | output | 64 | Registered transformed board |

## Verification
The bench builds the unit with its default column-index width of three bits. At that width the index is six bits, the word is 64 bits, and the zip chain is three stages long. This is what makes the byte-swap mirror, the 3-place index rotation of the transpose, and the full-reverse half turn all reachable. Round-trip checks feed the registered output back as the next input. They show that four quarter turns, and two transposes, return each of several boards unchanged.

// File: rtl/bbx_pkg.sv
package bbx_pkg;

  // Column coordinate width; the row uses the same width (square board).
  localparam int BB_X_BITS = 3;
  localparam int BB_IDX_W  = 2 * BB_X_BITS;
  localparam int BB_WORD_W = 1 << BB_IDX_W;
  localparam int BB_ZIP_W  = $clog2(BB_X_BITS + 1);

  typedef enum logic [2:0] {
    OP_KEEP      = 3'b000,
    OP_FLIP_H    = 3'b001,
    OP_FLIP_V    = 3'b010,
    OP_TURN180   = 3'b011,
    OP_TRANSPOSE = 3'b100,
    OP_TURN90    = 3'b101
  } xformOp_e;

  // Strobes passed from control to datapath.
  typedef struct packed {
    logic                load;
    logic [BB_IDX_W-1:0] revMask;
    logic [BB_ZIP_W-1:0] zipCount;
  } xformCtl_t;

endpackage

// File: rtl/bbx_zip_field.sv
// One generalized-zip stage: output index = input index with the field
// [HI:LO] rotated left by one place. Bypassed when en is low.
module bbx_zip_field #(
  parameter int IDX_W = 6,
  parameter int LO    = 0,
  parameter int HI    = IDX_W - 1
) (
  input  logic                  en,
  input  logic [(1<<IDX_W)-1:0] din,
  output logic [(1<<IDX_W)-1:0] dout
);
  localparam int W = 1 << IDX_W;

  // Inverse map: which input bit lands on output index dst.
  function automatic logic [IDX_W-1:0] srcIdx(input logic [IDX_W-1:0] dst);
    logic [IDX_W-1:0] s;
    s        = dst;
    s[HI:LO] = {dst[LO], dst[HI:LO+1]};
    return s;
  endfunction

  logic [W-1:0] shuffled;

  for (genvar j = 0; j < W; j++) begin : g_bit
    assign shuffled[j] = din[srcIdx(IDX_W'(j))];
  end

  assign dout = en ? shuffled : din;

endmodule

// File: rtl/bbx_ctrl.sv
// Opcode decode and valid pipeline.
module bbx_ctrl
  import bbx_pkg::*;
#(
  parameter int X_BITS = BB_X_BITS
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic [2:0] inOp,
  output xformCtl_t ctl,
  output logic      outValid
);
  localparam int IDX_W = 2 * X_BITS;
  localparam logic [IDX_W-1:0] COL_MASK = {{X_BITS{1'b0}}, {X_BITS{1'b1}}};
  localparam logic [IDX_W-1:0] ROW_MASK = {{X_BITS{1'b1}}, {X_BITS{1'b0}}};
  localparam logic [IDX_W-1:0] ALL_MASK = {IDX_W{1'b1}};
  localparam logic [BB_ZIP_W-1:0] HALF_ROT = BB_ZIP_W'(X_BITS);

  always_comb begin
    ctl.load     = inValid;
    ctl.revMask  = '0;
    ctl.zipCount = '0;
    case (inOp)
      OP_FLIP_H:    ctl.revMask = COL_MASK;
      OP_FLIP_V:    ctl.revMask = ROW_MASK;
      OP_TURN180:   ctl.revMask = ALL_MASK;
      OP_TRANSPOSE: ctl.zipCount = HALF_ROT;
      OP_TURN90: begin
        ctl.revMask  = ROW_MASK;
        ctl.zipCount = HALF_ROT;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  AST_VALID_RISES: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid) else $error("valid not forwarded");   // R2
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid) else $error("spurious valid");      // R2

endmodule

// File: rtl/bbx_datapath.sv
// Generalized reverse followed by a chain of zip stages, then the output register.
module bbx_datapath
  import bbx_pkg::*;
#(
  parameter int X_BITS = BB_X_BITS
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  xformCtl_t             ctl,
  input  logic [BB_WORD_W-1:0]  inBoard,
  output logic [BB_WORD_W-1:0]  outBoard
);
  localparam int IDX_W   = 2 * X_BITS;
  localparam int W       = 1 << IDX_W;
  localparam int ZIP_MAX = X_BITS;

  // Generalized reverse: output bit i takes input bit i XOR revMask, built
  // as one conditional swap layer per index bit.
  logic [W-1:0] revOut;
  always_comb begin
    logic [W-1:0] cur;
    logic [W-1:0] nxt;
    cur = inBoard;
    for (int s = 0; s < IDX_W; s++) begin
      for (int j = 0; j < W; j++) begin
        nxt[j] = ctl.revMask[s] ? cur[j ^ (1 << s)] : cur[j];
      end
      cur = nxt;
    end
    revOut = cur;
  end

  // Zip chain: stage z is active while the requested count exceeds z.
  logic [W-1:0] zipTap [ZIP_MAX+1];
  assign zipTap[0] = revOut;

  for (genvar z = 0; z < ZIP_MAX; z++) begin : g_zip
    logic stageEn;
    assign stageEn = (ctl.zipCount > BB_ZIP_W'(z));
    bbx_zip_field #(.IDX_W(IDX_W), .LO(0), .HI(IDX_W-1)) u_zip (
      .en   (stageEn),
      .din  (zipTap[z]),
      .dout (zipTap[z+1])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         outBoard <= '0;
    else if (ctl.load) outBoard <= zipTap[ZIP_MAX];
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(outBoard)) else $error("output moved while idle"); // R3
  AST_POP_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> ($countones(outBoard) == $countones($past(inBoard))))
    else $error("set-bit count changed");                                    // R10

endmodule

// File: rtl/bbx_transform.sv
module bbx_transform
  import bbx_pkg::*;
#(
  parameter int X_BITS = BB_X_BITS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [2:0]           inOp,
  input  logic [BB_WORD_W-1:0] inBoard,
  output logic                 outValid,
  output logic [BB_WORD_W-1:0] outBoard
);
  localparam int W = 1 << (2 * X_BITS);

  xformCtl_t ctl;

  bbx_ctrl #(.X_BITS(X_BITS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inOp     (inOp),
    .ctl      (ctl),
    .outValid (outValid)
  );

  bbx_datapath #(.X_BITS(X_BITS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .inBoard  (inBoard),
    .outBoard (outBoard)
  );

  AST_KEEP_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (inOp == 3'b000 || inOp == 3'b110 || inOp == 3'b111))
      |=> (outBoard == $past(inBoard))) else $error("keep altered word"); // R4
  AST_HALF_CORNER: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inOp == 3'b011) |=> (outBoard[0] == $past(inBoard[W-1])))
    else $error("half turn corner wrong");                                // R7

endmodule

// File: tb/bbx_transform_test.sv
module bbx_transform_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  inOp = 3'b000;
  logic [63:0] inBoard = '0;
  logic        outValid;
  logic [63:0] outBoard;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bbx_transform uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOp(inOp),
    .inBoard(inBoard), .outValid(outValid), .outBoard(outBoard)
  );

  // Reference mapping taken from the requirements.
  function automatic logic [63:0] refXform(input logic [2:0] op, input logic [63:0] b);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < 64; i++) begin
      logic [5:0] k;
      logic [5:0] t;
      logic [5:0] d;
      k = 6'(i);
      case (op)
        3'b001: d = k ^ 6'd7;
        3'b010: d = k ^ 6'd56;
        3'b011: d = k ^ 6'd63;
        3'b100: d = {k[2:0], k[5:3]};
        3'b101: begin t = k ^ 6'd56; d = {t[2:0], t[5:3]}; end
        default: d = k;
      endcase
      r[d] = b[i];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // One transaction: drive at negedge, sample the registered result one cycle later.
  task automatic xfer(input logic [2:0] op, input logic [63:0] b,
                      output logic [63:0] res, output logic vld);
    @(negedge clk);
    inValid = 1'b1; inOp = op; inBoard = b;
    @(negedge clk);
    res = outBoard; vld = outValid;
    inValid = 1'b0;
  endtask

  task automatic testReset;
    @(negedge clk);
    check("R1 reset valid", 64'(outValid), 64'd0);
    check("R1 reset board", outBoard, 64'd0);
    rstN = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1 idle valid", 64'(outValid), 64'd0);
    check("R1 idle board", outBoard, 64'd0);
  endtask

  task automatic testCorners;
    logic [63:0] r; logic v;
    xfer(3'b001, 64'h1, r, v);
    check("R5 hmirror corner", r, 64'h80);
    check("R2 valid after accept", 64'(v), 64'd1);
    @(negedge clk);
    check("R2 valid drops", 64'(outValid), 64'd0);
    xfer(3'b010, 64'hFF, r, v);
    check("R6 vmirror row", r, 64'hFF00_0000_0000_0000);
    xfer(3'b011, 64'h1, r, v);
    check("R7 half turn corner", r, 64'h8000_0000_0000_0000);
    xfer(3'b100, 64'hFF, r, v);
    check("R8 transpose row to column", r, 64'h0101_0101_0101_0101);
    xfer(3'b101, 64'h1, r, v);
    check("R9 quarter turn corner", r, 64'h80);
  endtask

  task automatic testPatterns;
    logic [63:0] pats [4];
    logic [63:0] r; logic v;
    pats[0] = 64'h0123_4567_89AB_CDEF;
    pats[1] = 64'hF0E1_D2C3_B4A5_9687;
    pats[2] = 64'h8142_2418_1824_4281;
    pats[3] = 64'h0000_0000_0000_F00D;
    for (int p = 0; p < 4; p++) begin
      for (int op = 0; op < 8; op++) begin
        xfer(3'(op), pats[p], r, v);
        case (op)
          1: check("R5 hmirror pattern", r, refXform(3'(op), pats[p]));
          2: check("R6 vmirror pattern", r, refXform(3'(op), pats[p]));
          3: check("R7 half turn pattern", r, refXform(3'(op), pats[p]));
          4: check("R8 transpose pattern", r, refXform(3'(op), pats[p]));
          5: check("R9 quarter turn pattern", r, refXform(3'(op), pats[p]));
          default: check("R4 keep/unused code", r, pats[p]);
        endcase
        check("R10 set-bit count", 64'($countones(r)), 64'($countones(pats[p])));
      end
    end
  endtask

  task automatic testHold;
    logic [63:0] r; logic v; logic [63:0] held;
    xfer(3'b011, 64'h0000_0000_0000_00F3, r, v);
    held = r;
    @(negedge clk);
    inValid = 1'b0; inOp = 3'b101; inBoard = 64'hDEAD_BEEF_CAFE_F00D;
    @(negedge clk); @(negedge clk);
    check("R3 hold while idle", outBoard, held);
    check("R3 no valid while idle", 64'(outValid), 64'd0);
  endtask

  task automatic testRoundTrips;
    logic [63:0] starts [3];
    logic [63:0] cur; logic v;
    starts[0] = 64'h0000_0000_0000_0F0F;
    starts[1] = 64'h1234_0000_8000_0001;
    starts[2] = 64'hA5A5_3C3C_0FF0_5A5A;
    for (int s = 0; s < 3; s++) begin
      cur = starts[s];
      for (int k = 0; k < 4; k++) xfer(3'b101, cur, cur, v);
      check("R9 four quarter turns", cur, starts[s]);
      cur = starts[s];
      for (int k = 0; k < 2; k++) xfer(3'b100, cur, cur, v);
      check("R8 double transpose", cur, starts[s]);
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    testReset();
    testCorners();
    testPatterns();
    testHold();
    testRoundTrips();
    summary();
  end

endmodule